// File: doc/BRIEF.md
# Dual Multiply-Accumulate Unit

This block is the arithmetic core of a dual multiply-accumulate datapath. Every clock cycle two independent lanes each take their own 16-bit data word, multiply it by one 16-bit coefficient that both lanes share, and add the product to, or subtract it from, one of four 40-bit accumulators. Each lane picks its accumulator with an index. Operands are widened to 17 bits before the multiply. A per-lane select and a coefficient select choose whether each operand is sign or zero extended, so signed and unsigned arithmetic, and mixtures of the two, run on the same hardware.

A global saturate enable decides how each result that leaves a lane is bounded. With saturation on, the result is clamped to the signed 32-bit range held in 40 bits. With saturation off, the result wraps modulo 2^40. Either kind of range event sets a sticky flag on the accumulator that was written. The two lanes are expected to name different accumulators. If they collide, lane 0 alone writes and a one-cycle error pulse reports the collision. Accumulators are registers, so each result appears on the outputs after the clock edge that captures it.

Top module: `dual_mac`

## Requirements
- R1: While reset is held (rst_n low at a clock edge), all four accumulators become zero, all overflow flags clear and the collision output is 0.
- R2: Each data operand is extended to 17 bits with its sign bit when its data_signed_i bit is 1 (bit 0 for lane 0, bit 1 for lane 1), and with a zero otherwise. The coefficient follows coef_signed_i in the same way. The 34-bit signed product is sign extended to 40 bits.
- R3: sub_i bit l = 0 makes lane l add its product to the selected accumulator. sub_i bit l = 1 makes it subtract the product. The result is visible on the outputs after the next rising clock edge.
- R4: Both lanes complete one operation in the same cycle, each reading the value its accumulator held before that edge.
- R5: With sat_en_i = 1, a result above 2^31-1 is stored as 0x007FFFFFFF and a result below -2^31 is stored as 0xFF80000000. The overflow flag of that accumulator is set.
- R6: With sat_en_i = 0, a result outside the signed 40-bit range wraps modulo 2^40 and sets the overflow flag of that accumulator. A result inside the range leaves the flag unchanged.
- R7: If both lanes are enabled and sel0_i equals sel1_i, only lane 0 writes, and conflict_o is 1 for exactly the cycle after that edge. Otherwise conflict_o is 0.
- R8: A lane whose lane_en_i bit is 0 changes no accumulator and no flag, whatever its other inputs are.
- R9: An overflow flag, once set, stays set until reset.
- R10: Accumulator index k (0 to 3) appears on acc_flat_o[40*k+39:40*k], and its flag appears on ovf_o[k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_en_i | input | 2 | Operation enable per lane (bit l = lane l) |
| data0_i | input | 16 | Data operand of lane 0 |
| data1_i | input | 16 | Data operand of lane 1 |
| coef_i | input | 16 | Coefficient shared by both lanes |
| data_signed_i | input | 2 | 1 = sign extend the data operand of that lane |
| coef_signed_i | input | 1 | 1 = sign extend the coefficient |
| sub_i | input | 2 | 1 = subtract the product for that lane, 0 = add it |
| sat_en_i | input | 1 | 1 = clamp results to the signed 32-bit range |
| sel0_i | input | 2 | Accumulator index for lane 0 |
| sel1_i | input | 2 | Accumulator index for lane 1 |
| acc_flat_o | output | 160 | Four 40-bit accumulators, index 0 in the low bits |
| ovf_o | output | 4 | Sticky overflow flag per accumulator |
| conflict_o | output | 1 | One-cycle pulse after a same-accumulator collision |

## Verification
The embedded assertions assume that every control input is a known 0 or 1 at each rising edge once reset has been released. They also assume that reset is held for at least one edge, so that the accumulators start from zero. The stimulus changes inputs only on falling edges and holds reset for several cycles at the start. It idles both lanes between scenarios, so no operation is ever half applied. The collision property only checks that the pulse follows a clash, so the bench also drives two lanes onto one accumulator on purpose and then runs a clean cycle to see the pulse drop.

// File: rtl/dual_mac_pkg.sv
// Shared constants for the dual multiply-accumulate unit.
// Assumes: a two's-complement datapath; the sizes below are the defaults
// used by every module of the block.
package dual_mac_pkg;
    localparam int unsigned DMAC_DATA_W = 16;
    localparam int unsigned DMAC_ACC_W  = 40;
    localparam int unsigned DMAC_N_ACC  = 4;
    localparam int unsigned DMAC_SAT_W  = 32;
    localparam int unsigned DMAC_LANES  = 2;
endpackage

// File: rtl/dmac_lane.sv
// One multiply-accumulate lane, purely combinational.
// Extends data and coefficient by one bit (sign or zero), multiplies them,
// sign extends the product to the accumulator width, then adds or subtracts
// it and bounds the result either by clamping or by wrapping.
// Assumes: ACC_W > 2*(DATA_W+1) and SAT_W < ACC_W.
module dmac_lane #(
    parameter int unsigned DATA_W = dual_mac_pkg::DMAC_DATA_W,
    parameter int unsigned ACC_W  = dual_mac_pkg::DMAC_ACC_W,
    parameter int unsigned SAT_W  = dual_mac_pkg::DMAC_SAT_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] coef_i,
    input  logic              data_signed_i,
    input  logic              coef_signed_i,
    input  logic              sub_i,
    input  logic              sat_en_i,
    input  logic [ACC_W-1:0]  acc_i,
    output logic [ACC_W-1:0]  res_o,
    output logic              range_evt_o
);
    localparam int unsigned MW = DATA_W + 1;
    localparam int unsigned PW = 2 * MW;
    localparam logic [ACC_W:0] ONE = {{ACC_W{1'b0}}, 1'b1};
    localparam logic signed [ACC_W:0] LIM_HI = $signed((ONE << (SAT_W - 1)) - ONE);
    localparam logic signed [ACC_W:0] LIM_LO = $signed(~((ONE << (SAT_W - 1)) - ONE));

    logic signed [MW-1:0]    d_ext;
    logic signed [MW-1:0]    c_ext;
    logic signed [PW-1:0]    prod;
    logic signed [ACC_W:0]   prod_wide;
    logic signed [ACC_W:0]   acc_wide;
    logic signed [ACC_W:0]   sum;
    logic                    wrap_ovf;
    logic                    over_hi;
    logic                    under_lo;

    // Operand widening and the 17x17 multiply.
    always_comb begin
        d_ext     = $signed({data_signed_i & data_i[DATA_W-1], data_i});
        c_ext     = $signed({coef_signed_i & coef_i[DATA_W-1], coef_i});
        prod      = d_ext * c_ext;
        prod_wide = $signed({{(ACC_W + 1 - PW){prod[PW-1]}}, prod});
        acc_wide  = $signed({acc_i[ACC_W-1], acc_i});
    end

    // Add or subtract one bit wider than the accumulator to see every overflow.
    always_comb begin
        sum      = sub_i ? (acc_wide - prod_wide) : (acc_wide + prod_wide);
        wrap_ovf = sum[ACC_W] ^ sum[ACC_W-1];
        over_hi  = sum > LIM_HI;
        under_lo = sum < LIM_LO;
    end

    // Bound the result: clamp when saturating, otherwise keep the low bits.
    always_comb begin
        if (sat_en_i && over_hi) begin
            res_o = LIM_HI[ACC_W-1:0];
        end else if (sat_en_i && under_lo) begin
            res_o = LIM_LO[ACC_W-1:0];
        end else begin
            res_o = sum[ACC_W-1:0];
        end
        range_evt_o = sat_en_i ? (over_hi | under_lo) : wrap_ovf;
    end
endmodule

// File: rtl/dmac_acc_bank.sv
// Accumulator register file with sticky overflow flags.
// Each lane writes at most one entry per cycle. When two write strobes hit
// one entry, the lower-numbered lane wins (the top masks clashes anyway).
// Assumes: synchronous active-low reset.
module dmac_acc_bank #(
    parameter int unsigned ACC_W = dual_mac_pkg::DMAC_ACC_W,
    parameter int unsigned N_ACC = dual_mac_pkg::DMAC_N_ACC,
    parameter int unsigned LANES = dual_mac_pkg::DMAC_LANES,
    localparam int unsigned SEL_W = $clog2(N_ACC)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [LANES-1:0]                 we_i,
    input  logic [LANES-1:0][SEL_W-1:0]      sel_i,
    input  logic [LANES-1:0][ACC_W-1:0]      val_i,
    input  logic [LANES-1:0]                 evt_i,
    output logic [N_ACC-1:0][ACC_W-1:0]      acc_o,
    output logic [N_ACC-1:0]                 ovf_o
);
    logic [N_ACC-1:0][ACC_W-1:0] acc_q;
    logic [N_ACC-1:0]            ovf_q;
    logic [N_ACC-1:0]            hit;

    // Which entries receive a write this cycle.
    always_comb begin
        hit = '0;
        for (int l = 0; l < LANES; l++) begin
            if (we_i[l]) hit[sel_i[l]] = 1'b1;
        end
    end

    // Register update; the loop runs high lane to low so lane 0 lands last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= '0;
        end else begin
            for (int l = LANES - 1; l >= 0; l--) begin
                if (we_i[l]) begin
                    acc_q[sel_i[l]] <= val_i[l];
                    if (evt_i[l]) ovf_q[sel_i[l]] <= 1'b1;
                end
            end
        end
    end

    assign acc_o = acc_q;
    assign ovf_o = ovf_q;

    generate
        for (genvar i = 0; i < N_ACC; i++) begin : g_chk
            assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !hit[i] |=> ($stable(acc_q[i]) && $stable(ovf_q[i])));
            assert_sticky_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
                ovf_q[i] |=> ovf_q[i]);
        end
    endgenerate
endmodule

// File: rtl/dual_mac.sv
// Dual multiply-accumulate unit: two lanes sharing one coefficient, four
// accumulators. Resolves lane collisions (lane 0 wins), reads each lane's
// source accumulator and flattens the bank onto the output bus.
// Assumes: inputs are stable around the rising edge; synchronous active-low reset.
module dual_mac #(
    parameter int unsigned DATA_W = dual_mac_pkg::DMAC_DATA_W,
    parameter int unsigned ACC_W  = dual_mac_pkg::DMAC_ACC_W,
    parameter int unsigned N_ACC  = dual_mac_pkg::DMAC_N_ACC,
    parameter int unsigned SAT_W  = dual_mac_pkg::DMAC_SAT_W,
    localparam int unsigned SEL_W = $clog2(N_ACC),
    localparam int unsigned LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       lane_en_i,
    input  logic [DATA_W-1:0]      data0_i,
    input  logic [DATA_W-1:0]      data1_i,
    input  logic [DATA_W-1:0]      coef_i,
    input  logic [LANES-1:0]       data_signed_i,
    input  logic                   coef_signed_i,
    input  logic [LANES-1:0]       sub_i,
    input  logic                   sat_en_i,
    input  logic [SEL_W-1:0]       sel0_i,
    input  logic [SEL_W-1:0]       sel1_i,
    output logic [N_ACC*ACC_W-1:0] acc_flat_o,
    output logic [N_ACC-1:0]       ovf_o,
    output logic                   conflict_o
);
    localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};
    localparam logic signed [ACC_W-1:0] LIM_HI = $signed((ONE << (SAT_W - 1)) - ONE);
    localparam logic signed [ACC_W-1:0] LIM_LO = $signed(~((ONE << (SAT_W - 1)) - ONE));

    logic [LANES-1:0][DATA_W-1:0] data;
    logic [LANES-1:0][SEL_W-1:0]  sel;
    logic [LANES-1:0][ACC_W-1:0]  src;
    logic [LANES-1:0][ACC_W-1:0]  res;
    logic [LANES-1:0]             evt;
    logic [LANES-1:0]             we;
    logic [N_ACC-1:0][ACC_W-1:0]  acc;
    logic                         clash;
    logic                         conflict_q;

    assign data = {data1_i, data0_i};
    assign sel  = {sel1_i, sel0_i};

    // Collision detection: lane 1 is dropped when it names lane 0's accumulator.
    always_comb begin
        clash = lane_en_i[0] && lane_en_i[1] && (sel0_i == sel1_i);
        we    = {lane_en_i[1] && !clash, lane_en_i[0]};
    end

    // Collision pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) conflict_q <= 1'b0;
        else        conflict_q <= clash;
    end
    assign conflict_o = conflict_q;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign src[l] = acc[sel[l]];
            dmac_lane #(
                .DATA_W (DATA_W),
                .ACC_W  (ACC_W),
                .SAT_W  (SAT_W)
            ) u_lane (
                .data_i        (data[l]),
                .coef_i        (coef_i),
                .data_signed_i (data_signed_i[l]),
                .coef_signed_i (coef_signed_i),
                .sub_i         (sub_i[l]),
                .sat_en_i      (sat_en_i),
                .acc_i         (src[l]),
                .res_o         (res[l]),
                .range_evt_o   (evt[l])
            );
            assert_sat_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (we[l] && sat_en_i) |->
                    (($signed(res[l]) <= LIM_HI) && ($signed(res[l]) >= LIM_LO)));
        end
        for (genvar i = 0; i < N_ACC; i++) begin : g_flat
            assign acc_flat_o[i*ACC_W +: ACC_W] = acc[i];
        end
    endgenerate

    dmac_acc_bank #(
        .ACC_W (ACC_W),
        .N_ACC (N_ACC),
        .LANES (LANES)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (we),
        .sel_i (sel),
        .val_i (res),
        .evt_i (evt),
        .acc_o (acc),
        .ovf_o (ovf_o)
    );

    assert_conflict_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_en_i[0] && lane_en_i[1] && (sel0_i == sel1_i)) |=> conflict_o);
    assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(we[0] && we[1] && (sel[0] == sel[1])));
endmodule

// File: tb/sim_dual_mac.sv
`timescale 1ns/1ps
module sim_dual_mac;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   lane_en = '0;
    logic [15:0]  d0 = '0, d1 = '0, coef = '0;
    logic [1:0]   dsg = '0;
    logic         csg = 1'b0;
    logic [1:0]   sb = '0;
    logic         sat = 1'b0;
    logic [1:0]   s0 = '0, s1 = '0;
    logic [159:0] acc_flat;
    logic [3:0]   ovf;
    logic         conflict;

    int checks = 0;
    int errors = 0;

    logic [39:0] m_acc [4];
    logic [3:0]  m_ovf;
    logic        m_conf;

    always #10 clk = ~clk;

    dual_mac u0 (
        .clk(clk), .rst_n(rst_n), .lane_en_i(lane_en),
        .data0_i(d0), .data1_i(d1), .coef_i(coef),
        .data_signed_i(dsg), .coef_signed_i(csg), .sub_i(sb), .sat_en_i(sat),
        .sel0_i(s0), .sel1_i(s1),
        .acc_flat_o(acc_flat), .ovf_o(ovf), .conflict_o(conflict)
    );

    // Compare every output with the model; one check per call.
    task automatic check_all(input string tag);
        bit bad = 0;
        checks++;
        for (int k = 0; k < 4; k++) begin
            if (acc_flat[40*k +: 40] !== m_acc[k]) begin
                bad = 1;
                $display("FAIL %s acc%0d actual=%h expected=%h", tag, k, acc_flat[40*k +: 40], m_acc[k]);
            end
        end
        if (ovf !== m_ovf) begin
            bad = 1;
            $display("FAIL %s ovf actual=%b expected=%b", tag, ovf, m_ovf);
        end
        if (conflict !== m_conf) begin
            bad = 1;
            $display("FAIL %s conflict actual=%b expected=%b", tag, conflict, m_conf);
        end
        if (bad) errors++;
    endtask

    // Model of one lane from the requirements (R2, R3, R5, R6).
    task automatic lane_model(input logic [15:0] d, input logic ds, input logic [39:0] old,
                              input logic sub, output logic [39:0] nv, output logic ev);
        longint dv, cv, p, s;
        dv = ds ? longint'($signed(d)) : longint'(d);
        cv = csg ? longint'($signed(coef)) : longint'(coef);
        p  = dv * cv;
        s  = longint'($signed(old));
        s  = sub ? s - p : s + p;
        ev = 0;
        if (sat && s > 64'sd2147483647) begin
            s = 64'sd2147483647; ev = 1;
        end else if (sat && s < -64'sd2147483648) begin
            s = -64'sd2147483648; ev = 1;
        end else if (!sat && (s > 64'sd549755813887 || s < -64'sd549755813888)) begin
            ev = 1;
        end
        nv = s[39:0];
    endtask

    // One operation cycle: drive, update the model, check after the edge.
    task automatic step(input logic [1:0] en, input logic [15:0] a0, input logic [15:0] a1,
                        input logic [15:0] c, input logic [1:0] ds, input logic cs,
                        input logic [1:0] sub, input logic st, input logic [1:0] q0,
                        input logic [1:0] q1, input string tag);
        logic [39:0] v0, v1;
        logic e0, e1, clash;
        lane_en = en; d0 = a0; d1 = a1; coef = c; dsg = ds; csg = cs;
        sb = sub; sat = st; s0 = q0; s1 = q1;
        clash = en[0] && en[1] && (q0 == q1);
        lane_model(a0, ds[0], m_acc[q0], sub[0], v0, e0);
        lane_model(a1, ds[1], m_acc[q1], sub[1], v1, e1);
        if (en[1] && !clash) begin m_acc[q1] = v1; if (e1) m_ovf[q1] = 1'b1; end
        if (en[0])           begin m_acc[q0] = v0; if (e0) m_ovf[q0] = 1'b1; end
        m_conf = clash;
        @(posedge clk);
        @(negedge clk);
        lane_en = '0;
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        m_conf = 1'b0;
        lane_en = '0;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic t_reset();
        for (int k = 0; k < 4; k++) m_acc[k] = '0;
        m_ovf = '0; m_conf = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 reset state");
        rst_n = 1'b1;
        idle("R1 after release");
    endtask

    task automatic t_extension();
        // lane0: signed -1 * 3 into acc0; lane1: unsigned 0xFFFF * 3 into acc1
        step(2'b11, 16'hFFFF, 16'hFFFF, 16'd3, 2'b01, 1'b0, 2'b00, 1'b0, 2'd0, 2'd1, "R2 R4 R10 ext");
        // signed coefficient -2 against signed data 0x8000 into acc2 / acc3 unsigned data
        step(2'b11, 16'h8000, 16'h8000, 16'hFFFE, 2'b01, 1'b1, 2'b00, 1'b0, 2'd2, 2'd3, "R2 coef sign");
    endtask

    task automatic t_subtract();
        step(2'b11, 16'd100, 16'd7, 16'd5, 2'b11, 1'b1, 2'b11, 1'b0, 2'd1, 2'd0, "R3 subtract");
        step(2'b01, 16'd9, 16'd0, 16'd9, 2'b00, 1'b0, 2'b01, 1'b0, 2'd2, 2'd0, "R3 mixed");
    endtask

    task automatic t_disabled();
        step(2'b00, 16'h7FFF, 16'h1234, 16'h7FFF, 2'b11, 1'b1, 2'b00, 1'b0, 2'd0, 2'd1, "R8 disabled");
        step(2'b10, 16'h7FFF, 16'd0, 16'h7FFF, 2'b00, 1'b0, 2'b00, 1'b1, 2'd3, 2'd3, "R8 lane0 off");
    endtask

    task automatic t_saturate();
        step(2'b01, 16'hFFFF, 16'd0, 16'hFFFF, 2'b00, 1'b0, 2'b00, 1'b1, 2'd2, 2'd0, "R5 clamp high");
        if (acc_flat[80 +: 40] !== 40'h007FFFFFFF) begin
            errors++; $display("FAIL R5 high value actual=%h expected=%h", acc_flat[80 +: 40], 40'h007FFFFFFF);
        end
        checks++;
        step(2'b01, 16'hFFFF, 16'd0, 16'hFFFF, 2'b00, 1'b0, 2'b01, 1'b1, 2'd2, 2'd0, "R5 sub inside");
        step(2'b01, 16'hFFFF, 16'd0, 16'hFFFF, 2'b00, 1'b0, 2'b01, 1'b1, 2'd2, 2'd0, "R5 clamp low");
        if (acc_flat[80 +: 40] !== 40'hFF80000000) begin
            errors++; $display("FAIL R5 low value actual=%h expected=%h", acc_flat[80 +: 40], 40'hFF80000000);
        end
        checks++;
    endtask

    task automatic t_wrap();
        for (int n = 0; n < 130; n++)
            step(2'b01, 16'hFFFF, 16'd0, 16'hFFFF, 2'b00, 1'b0, 2'b00, 1'b0, 2'd3, 2'd0, "R6 wrap run");
        checks++;
        if (ovf[3] !== 1'b1) begin
            errors++; $display("FAIL R6 wrap flag actual=%b expected=1", ovf[3]);
        end
    endtask

    task automatic t_sticky();
        step(2'b01, 16'd1, 16'd0, 16'd1, 2'b00, 1'b0, 2'b00, 1'b0, 2'd3, 2'd0, "R9 sticky after ok op");
        step(2'b10, 16'd0, 16'd2, 16'd2, 2'b00, 1'b0, 2'b00, 1'b1, 2'd0, 2'd2, "R9 sticky sat acc2");
        idle("R9 idle");
    endtask

    task automatic t_conflict();
        step(2'b11, 16'd10, 16'd20, 16'd3, 2'b00, 1'b0, 2'b00, 1'b0, 2'd1, 2'd1, "R7 clash");
        step(2'b11, 16'd1, 16'd1, 16'd1, 2'b00, 1'b0, 2'b00, 1'b0, 2'd0, 2'd1, "R7 pulse drops");
        idle("R7 idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_extension();
        t_subtract();
        t_disabled();
        t_saturate();
        t_wrap();
        t_sticky();
        t_conflict();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule